// File: doc/BRIEF.md
# Segmented Physical Address Generator

This block turns a 16-bit offset into a 20-bit memory address the way a segmented 16-bit processor does it. It keeps four 16-bit segment bases (code, data, stack, extra), takes the current values of two base pointers, two index pointers and the instruction pointer, and forms an effective address from the operand pattern named by an addressing-mode input. It then shifts the chosen segment base left by four bits and adds the effective address.

The segment is picked from the operand pattern alone. Instruction fetches use the code segment. Any operand that names the base pointer as its base uses the stack segment. Every other data operand uses the data segment. The extra segment can be written and is held, but no mode selects it on its own.

A parameter places a register stage on all outputs. The default has the stage, which gives one cycle of latency. With the stage removed, the address path is purely combinational from the request inputs.

Top module: `seg_addr_gen`

## Requirements
- R1: `phys_addr` equals (segment base × 16) + `eff_addr`, taken modulo 2^20, so a sum past FFFFFh wraps to the bottom of memory. For example, data base 7205h with offset 0030h gives 72080h.
- R2: Mode code 6 (fetch) gives `eff_addr` = `ip` and selects the code segment.
- R3: Mode code 1 (pointer-indirect) gives `eff_addr` equal to the pointer named by `ptr_sel`: 0 = `reg_bx`, 1 = `reg_bp`, 2 = `reg_si`, 3 = `reg_di`.
- R4: `seg_id` uses the encoding 0 = code, 1 = data, 2 = stack, 3 = extra. It is stack whenever the base pointer is the base: mode 1 with `ptr_sel`=1, or modes 2, 4 and 5 with `base_sel`=1. It is code in mode 6 and data in every other case. It is never extra.
- R5: Mode codes 0 and 7 (direct) give `eff_addr` equal to all 16 bits of `disp`, whatever the value of `disp_wide`, and select the data segment.
- R6: Mode 2 (based) adds the displacement to the base chosen by `base_sel` (0 = `reg_bx`, 1 = `reg_bp`). Mode 3 (indexed) adds it to the index chosen by `idx_sel` (0 = `reg_si`, 1 = `reg_di`). When `disp_wide`=1 the displacement is all of `disp`. When `disp_wide`=0 it is `disp[7:0]` sign-extended, and `disp[15:8]` is ignored.
- R7: Mode 4 (based-indexed) adds the selected base to the selected index. Mode 5 adds the displacement as well, under the same width rule as R6.
- R8: Every effective-address sum wraps modulo 2^16.
- R9: When `seg_we`=1 at a rising edge, `seg_wdata` is written into the segment named by `seg_wsel` (same encoding as R4). Requests from the next cycle on use the new value. Reset clears all four bases to 0.
- R10: With the default output register, the outputs show the result for the request present at the previous rising edge. While reset is held, every output is 0.
- R11: `seg_base` shows the 16-bit base of the segment named by `seg_id`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| seg_we | input | 1 | Segment base write enable |
| seg_wsel | input | 2 | Segment to write (0 code, 1 data, 2 stack, 3 extra) |
| seg_wdata | input | 16 | New segment base |
| amode | input | 3 | Addressing mode code |
| ptr_sel | input | 2 | Pointer used by pointer-indirect mode |
| base_sel | input | 1 | Base pointer choice: 0 bx, 1 bp |
| idx_sel | input | 1 | Index pointer choice: 0 si, 1 di |
| reg_bx | input | 16 | General base pointer value |
| reg_bp | input | 16 | Stack base pointer value |
| reg_si | input | 16 | Source index value |
| reg_di | input | 16 | Destination index value |
| ip | input | 16 | Instruction pointer |
| disp | input | 16 | Displacement field |
| disp_wide | input | 1 | 1: 16-bit displacement, 0: sign-extended low byte |
| phys_addr | output | 20 | Physical address |
| eff_addr | output | 16 | Effective address |
| seg_id | output | 2 | Selected segment |
| seg_base | output | 16 | Base value of the selected segment |

## Verification
The bench goes after carries and wraps. A 16-bit offset sum that overflows must drop its carry rather than leak it into the physical address. A segment base near the top must wrap to the bottom of memory rather than saturate or widen. A short displacement with its top bit set must subtract, so a design that zero-extends it lands 256 bytes high. The bench also looks at segment choice: a design that keys the stack segment on the wrong pointer sends base-pointer accesses to the data base. A segment write used on the very next request catches a design that reads a stale copy of the base.

// File: rtl/sag_pkg.sv
package sag_pkg;

    localparam int OFS_W   = 16;
    localparam int SEG_W   = 16;
    localparam int SHIFT_W = 4;
    localparam int PHYS_W  = SEG_W + SHIFT_W;
    localparam int NSEG    = 4;
    localparam int SEL_W   = $clog2(NSEG);
    localparam int SDISP_W = 8;

    typedef logic [OFS_W-1:0]  ofs_t;
    typedef logic [SEG_W-1:0]  segv_t;
    typedef logic [PHYS_W-1:0] phys_t;

    typedef enum logic [2:0] {
        AM_DIRECT    = 3'd0,
        AM_PTR       = 3'd1,
        AM_BASED     = 3'd2,
        AM_INDEXED   = 3'd3,
        AM_BIDX      = 3'd4,
        AM_BIDX_DISP = 3'd5,
        AM_FETCH     = 3'd6,
        AM_SPARE     = 3'd7
    } amode_e;

    typedef enum logic [SEL_W-1:0] {
        SG_CODE  = 2'd0,
        SG_DATA  = 2'd1,
        SG_STACK = 2'd2,
        SG_EXTRA = 2'd3
    } seg_e;

    typedef struct packed {
        ofs_t bx;
        ofs_t bp;
        ofs_t si;
        ofs_t di;
        ofs_t ip;
    } ptrs_t;

    typedef struct packed {
        amode_e          mode;
        logic [1:0]      ptr_sel;
        logic            base_sel;
        logic            idx_sel;
        ofs_t            disp;
        logic            disp_wide;
    } req_t;

    typedef struct packed {
        ofs_t ea;
        seg_e seg;
    } ea_res_t;

    typedef struct packed {
        phys_t phys;
        ofs_t  ea;
        seg_e  seg;
        segv_t base;
    } out_t;

    function automatic ofs_t widen_disp(input ofs_t d, input logic wide);
        ofs_t r;
        if (wide) r = d;
        else      r = {{(OFS_W-SDISP_W){d[SDISP_W-1]}}, d[SDISP_W-1:0]};
        return r;
    endfunction

    function automatic phys_t reloc(input segv_t b, input ofs_t e);
        phys_t shifted;
        phys_t ext;
        shifted = {b, {SHIFT_W{1'b0}}};
        ext     = {{(PHYS_W-OFS_W){1'b0}}, e};
        return shifted + ext;
    endfunction

endpackage

// File: rtl/sag_seg_file.sv
module sag_seg_file
    import sag_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              we,
    input  logic [SEL_W-1:0]  wsel,
    input  segv_t             wdata,
    input  seg_e              rsel,
    output segv_t             rdata
);
    segv_t bank [NSEG];

    for (genvar g = 0; g < NSEG; g++) begin : g_seg
        always_ff @(posedge clk) begin
            if (rst)                                  bank[g] <= '0;
            else if (we && wsel == SEL_W'(g))         bank[g] <= wdata;
        end
    end

    assign rdata = bank[rsel];
endmodule

// File: rtl/sag_ea_unit.sv
module sag_ea_unit
    import sag_pkg::*;
(
    input  req_t    req,
    input  ptrs_t   ptrs,
    output ea_res_t res
);
    ofs_t d_ext;
    ofs_t base_v;
    ofs_t idx_v;
    seg_e base_seg;

    always_comb begin
        d_ext    = widen_disp(req.disp, req.disp_wide);
        base_v   = req.base_sel ? ptrs.bp : ptrs.bx;
        idx_v    = req.idx_sel  ? ptrs.di : ptrs.si;
        base_seg = req.base_sel ? SG_STACK : SG_DATA;
    end

    always_comb begin
        res.ea  = req.disp;
        res.seg = SG_DATA;
        unique case (req.mode)
            AM_PTR: begin
                unique case (req.ptr_sel)
                    2'd0: res.ea = ptrs.bx;
                    2'd1: res.ea = ptrs.bp;
                    2'd2: res.ea = ptrs.si;
                    default: res.ea = ptrs.di;
                endcase
                res.seg = (req.ptr_sel == 2'd1) ? SG_STACK : SG_DATA;
            end
            AM_BASED: begin
                res.ea  = base_v + d_ext;
                res.seg = base_seg;
            end
            AM_INDEXED: begin
                res.ea  = idx_v + d_ext;
                res.seg = SG_DATA;
            end
            AM_BIDX: begin
                res.ea  = base_v + idx_v;
                res.seg = base_seg;
            end
            AM_BIDX_DISP: begin
                res.ea  = base_v + idx_v + d_ext;
                res.seg = base_seg;
            end
            AM_FETCH: begin
                res.ea  = ptrs.ip;
                res.seg = SG_CODE;
            end
            default: begin
                res.ea  = req.disp;
                res.seg = SG_DATA;
            end
        endcase
    end
endmodule

// File: rtl/sag_out_stage.sv
module sag_out_stage
    import sag_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
)(
    input  logic    clk,
    input  logic    rst,
    input  ea_res_t res,
    input  segv_t   base,
    output out_t    q
);
    out_t d;

    always_comb begin
        d.phys = reloc(base, res.ea);
        d.ea   = res.ea;
        d.seg  = res.seg;
        d.base = base;
    end

    if (REG_OUT) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst) q <= '0;
            else     q <= d;
        end
    end else begin : g_comb
        assign q = d;
    end
endmodule

// File: rtl/seg_addr_gen.sv
module seg_addr_gen
    import sag_pkg::*;
#(
    parameter bit REG_OUT = 1'b1
)(
    input  logic        clk,
    input  logic        rst,
    input  logic        seg_we,
    input  logic [1:0]  seg_wsel,
    input  logic [15:0] seg_wdata,
    input  logic [2:0]  amode,
    input  logic [1:0]  ptr_sel,
    input  logic        base_sel,
    input  logic        idx_sel,
    input  logic [15:0] reg_bx,
    input  logic [15:0] reg_bp,
    input  logic [15:0] reg_si,
    input  logic [15:0] reg_di,
    input  logic [15:0] ip,
    input  logic [15:0] disp,
    input  logic        disp_wide,
    output logic [19:0] phys_addr,
    output logic [15:0] eff_addr,
    output logic [1:0]  seg_id,
    output logic [15:0] seg_base
);
    req_t    req;
    ptrs_t   ptrs;
    ea_res_t ea_res;
    segv_t   base_rd;
    out_t    oq;

    always_comb begin
        req.mode      = amode_e'(amode);
        req.ptr_sel   = ptr_sel;
        req.base_sel  = base_sel;
        req.idx_sel   = idx_sel;
        req.disp      = disp;
        req.disp_wide = disp_wide;
        ptrs.bx = reg_bx;
        ptrs.bp = reg_bp;
        ptrs.si = reg_si;
        ptrs.di = reg_di;
        ptrs.ip = ip;
    end

    sag_ea_unit u_ea (
        .req  (req),
        .ptrs (ptrs),
        .res  (ea_res)
    );

    sag_seg_file u_segs (
        .clk   (clk),
        .rst   (rst),
        .we    (seg_we),
        .wsel  (seg_wsel),
        .wdata (seg_wdata),
        .rsel  (ea_res.seg),
        .rdata (base_rd)
    );

    sag_out_stage #(.REG_OUT(REG_OUT)) u_out (
        .clk  (clk),
        .rst  (rst),
        .res  (ea_res),
        .base (base_rd),
        .q    (oq)
    );

    assign phys_addr = oq.phys;
    assign eff_addr  = oq.ea;
    assign seg_id    = oq.seg;
    assign seg_base  = oq.base;
endmodule

// File: rtl/sag_checker.sv
module sag_checker #(
    parameter bit REG_OUT = 1'b1
)(
    input logic        clk,
    input logic        rst,
    input logic [2:0]  amode,
    input logic [1:0]  ptr_sel,
    input logic        base_sel,
    input logic [15:0] ip,
    input logic [15:0] disp,
    input logic [19:0] phys_addr,
    input logic [15:0] eff_addr,
    input logic [1:0]  seg_id
);
    logic [2:0]  m_q;
    logic [1:0]  p_q;
    logic        b_q;
    logic [15:0] ip_q;
    logic [15:0] d_q;
    logic        vld;

    if (REG_OUT) begin : g_lag
        always_ff @(posedge clk) begin
            if (rst) begin
                m_q <= '0; p_q <= '0; b_q <= 1'b0; ip_q <= '0; d_q <= '0; vld <= 1'b0;
            end else begin
                m_q <= amode; p_q <= ptr_sel; b_q <= base_sel;
                ip_q <= ip; d_q <= disp; vld <= 1'b1;
            end
        end
    end else begin : g_now
        assign m_q = amode;  assign p_q = ptr_sel; assign b_q = base_sel;
        assign ip_q = ip;    assign d_q = disp;
        always_ff @(posedge clk) vld <= !rst;
    end

    logic bp_based;
    assign bp_based = (m_q == 3'd1 && p_q == 2'd1) ||
                      ((m_q == 3'd2 || m_q == 3'd4 || m_q == 3'd5) && b_q);

    // R1: segment shift leaves the low nibble to the offset alone
    a_r1_low_nibble: assert property (@(posedge clk) disable iff (rst)
        vld |-> phys_addr[3:0] == eff_addr[3:0]);

    a_r2_fetch_code: assert property (@(posedge clk) disable iff (rst)
        (vld && m_q == 3'd6) |-> (seg_id == 2'd0 && eff_addr == ip_q));

    a_r4_stack_on_bp: assert property (@(posedge clk) disable iff (rst)
        (vld && bp_based) |-> seg_id == 2'd2);

    a_r4_never_extra: assert property (@(posedge clk) disable iff (rst)
        vld |-> seg_id != 2'd3);

    a_r5_direct_disp: assert property (@(posedge clk) disable iff (rst)
        (vld && (m_q == 3'd0 || m_q == 3'd7)) |-> (eff_addr == d_q && seg_id == 2'd1));
endmodule

bind seg_addr_gen sag_checker #(.REG_OUT(REG_OUT)) u_sag_chk (
    .clk       (clk),
    .rst       (rst),
    .amode     (amode),
    .ptr_sel   (ptr_sel),
    .base_sel  (base_sel),
    .ip        (ip),
    .disp      (disp),
    .phys_addr (phys_addr),
    .eff_addr  (eff_addr),
    .seg_id    (seg_id)
);

// File: tb/tb_seg_addr_gen.sv
module tb_seg_addr_gen;
    logic        clk = 1'b0;
    logic        rst;
    logic        seg_we;
    logic [1:0]  seg_wsel;
    logic [15:0] seg_wdata;
    logic [2:0]  amode;
    logic [1:0]  ptr_sel;
    logic        base_sel, idx_sel;
    logic [15:0] reg_bx, reg_bp, reg_si, reg_di, ip, disp;
    logic        disp_wide;
    logic [19:0] phys_addr;
    logic [15:0] eff_addr;
    logic [1:0]  seg_id;
    logic [15:0] seg_base;

    int checks = 0;
    int fails  = 0;
    logic [15:0] mirror [4];
    logic [31:0] seed_sink;

    always #5 clk = ~clk;

    seg_addr_gen dut (
        .clk(clk), .rst(rst), .seg_we(seg_we), .seg_wsel(seg_wsel), .seg_wdata(seg_wdata),
        .amode(amode), .ptr_sel(ptr_sel), .base_sel(base_sel), .idx_sel(idx_sel),
        .reg_bx(reg_bx), .reg_bp(reg_bp), .reg_si(reg_si), .reg_di(reg_di), .ip(ip),
        .disp(disp), .disp_wide(disp_wide),
        .phys_addr(phys_addr), .eff_addr(eff_addr), .seg_id(seg_id), .seg_base(seg_base)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] x_disp();
        return disp_wide ? disp : {{8{disp[7]}}, disp[7:0]};
    endfunction

    function automatic logic [15:0] x_ea();
        logic [15:0] b = base_sel ? reg_bp : reg_bx;
        logic [15:0] i = idx_sel ? reg_di : reg_si;
        case (amode)
            3'd1: return ptr_sel == 0 ? reg_bx : ptr_sel == 1 ? reg_bp : ptr_sel == 2 ? reg_si : reg_di;
            3'd2: return b + x_disp();
            3'd3: return i + x_disp();
            3'd4: return b + i;
            3'd5: return b + i + x_disp();
            3'd6: return ip;
            default: return disp;
        endcase
    endfunction

    function automatic logic [1:0] x_seg();
        case (amode)
            3'd6: return 2'd0;
            3'd1: return ptr_sel == 2'd1 ? 2'd2 : 2'd1;
            3'd2, 3'd4, 3'd5: return base_sel ? 2'd2 : 2'd1;
            default: return 2'd1;
        endcase
    endfunction

    function automatic string mtag();
        case (amode)
            3'd1: return "R3";
            3'd2, 3'd3: return "R6";
            3'd4, 3'd5: return "R7";
            3'd6: return "R2";
            default: return "R5";
        endcase
    endfunction

    task automatic wr_seg(input logic [1:0] s, input logic [15:0] v);
        @(negedge clk);
        seg_we = 1'b1; seg_wsel = s; seg_wdata = v;
        @(posedge clk);
        mirror[s] = v;
        @(negedge clk);
        seg_we = 1'b0;
    endtask

    // inputs already set; capture at next edge, sample at following negedge
    task automatic run_req();
        logic [15:0] e_ea;
        logic [1:0]  e_sg;
        logic [19:0] e_ph;
        string t;
        e_ea = x_ea();
        e_sg = x_seg();
        e_ph = ({4'd0, mirror[e_sg]} << 4) + {4'd0, e_ea};
        t = mtag();
        @(posedge clk);
        @(negedge clk);
        chk({t, "/R8 ea"}, 32'(eff_addr), 32'(e_ea));
        chk("R4 seg", 32'(seg_id), 32'(e_sg));
        chk("R1 phys", 32'(phys_addr), 32'(e_ph));
        chk("R11 base", 32'(seg_base), 32'(mirror[e_sg]));
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        seed_sink = $urandom(32'h5e6a_1d07);
        rst = 1'b1; seg_we = 0; seg_wsel = 0; seg_wdata = 0;
        amode = 3'd6; ptr_sel = 0; base_sel = 0; idx_sel = 0;
        reg_bx = 16'h1111; reg_bp = 16'h2222; reg_si = 16'h3333; reg_di = 16'h4444;
        ip = 16'h5555; disp = 16'h6666; disp_wide = 1;
        for (int k = 0; k < 4; k++) mirror[k] = 16'h0;
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R10 reset state
        chk("R10 rst phys", 32'(phys_addr), 0);
        chk("R10 rst ea", 32'(eff_addr), 0);
        chk("R10 rst seg", 32'(seg_id), 0);
        rst = 1'b0;

        // R9 reset cleared bases: fetch uses base 0
        run_req();
        chk("R9 cleared base", 32'(phys_addr), 32'h05555);

        // R1 worked example via pointer-indirect DI (R3)
        wr_seg(2'd1, 16'h7205);
        amode = 3'd1; ptr_sel = 2'd3; reg_di = 16'h0030;
        run_req();
        chk("R1 example", 32'(phys_addr), 32'h72080);

        // R1 wrap at top of memory
        wr_seg(2'd1, 16'hFFFF);
        amode = 3'd0; disp = 16'hFFFF; disp_wide = 0;
        run_req();
        chk("R1 wrap", 32'(phys_addr), 32'h0FFEF);
        chk("R5 wide ignored", 32'(eff_addr), 32'hFFFF);

        // R8 offset wrap: based BX FFF0 + short 20h
        amode = 3'd2; base_sel = 0; reg_bx = 16'hFFF0; disp = 16'hAB20; disp_wide = 0;
        run_req();
        chk("R8 wrap", 32'(eff_addr), 32'h0010);

        // R6 negative short displacement, high byte ignored
        amode = 3'd3; idx_sel = 0; reg_si = 16'h1000; disp = 16'h12F0;
        run_req();
        chk("R6 sext", 32'(eff_addr), 32'h0FF0);

        // R4 BP based-indexed with displacement -> stack
        wr_seg(2'd2, 16'h3000);
        amode = 3'd5; base_sel = 1; idx_sel = 1; reg_bp = 16'h0100; reg_di = 16'h0020;
        disp = 16'h0004; disp_wide = 1;
        run_req();
        chk("R4 stack phys", 32'(phys_addr), 32'h30124);

        // R9 write then immediate use; extra never selected
        wr_seg(2'd3, 16'hBEEF);
        wr_seg(2'd0, 16'h1234);
        amode = 3'd6; ip = 16'h0010;
        run_req();
        chk("R9 new base", 32'(phys_addr), 32'h12350);

        // R7 spare code 7 behaves direct (R5)
        amode = 3'd7; disp = 16'h4321;
        run_req();

        // random mix
        for (int n = 0; n < 400; n++) begin
            if ($urandom_range(0, 3) == 0)
                wr_seg(2'($urandom_range(0, 3)), 16'($urandom()));
            amode = 3'($urandom_range(0, 7));
            ptr_sel = 2'($urandom_range(0, 3));
            base_sel = 1'($urandom_range(0, 1));
            idx_sel = 1'($urandom_range(0, 1));
            reg_bx = 16'($urandom()); reg_bp = 16'($urandom());
            reg_si = 16'($urandom()); reg_di = 16'($urandom());
            ip = 16'($urandom()); disp = 16'($urandom());
            disp_wide = 1'($urandom_range(0, 1));
            run_req();
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule